// File: doc/BRIEF.md
# Two-Cycle Memory Access Sequencer

This block sits between a small two-stage processor datapath and one memory port that answers reads in the same cycle as the address is given. On every ordinary cycle it places the instruction address on the port and latches the returned word as the current opcode. When the datapath asks for a load or a store, the sequencer takes one extra cycle for the data. In the first cycle it still fetches, and parks the fetched word in a next-opcode register. In the second cycle it drives the data address and performs the access. The parked word then becomes the current opcode.

On the data side it works out which byte lanes an access touches from the two low address bits, the access size and a 2-bit byte-order input. Store data is copied onto every lane it could occupy, and the lane selects decide which bytes the memory writes. Load data is shifted down to the low bits and sign- or zero-extended. An external pause input freezes all state while the memory is not ready.

Top module: `memacc_ctrl`

## Requirements
- R1: With `acc_size_i` = 00 (no access) and `pause_i` low, `mem_addr_o` equals `pc_i`, and at the next rising edge `opcode_o` takes the value of `mem_rdata_i`.
- R2: A load or store (`acc_size_i` 01 byte, 10 halfword, 11 word) takes two cycles. In the first, `mem_addr_o` = `pc_i` and `stall_o` = 1. In the second, `mem_addr_o` = `dat_addr_i` and `stall_o` = 0 (unless paused).
- R3: `mem_we_o` is high only in the second cycle of an access that has `acc_wr_i` = 1.
- R4: Lane numbering: lane n is `mem_*data` bits [8n+7:8n]. With `endian_i` = 00 (big-endian), the byte at address offset k sits in lane 3-k, and a halfword at offset 0 uses lanes 3..2 while one at offset 2 uses lanes 1..0. With `endian_i` = 11 (little-endian), byte k sits in lane k and a halfword at offset 0 uses lanes 1..0. Halfword accesses ignore address bit 0, and word accesses use all four lanes.
- R5: `mem_sel_o` (bit n = lane n) holds the R4 lane set while `mem_we_o` is high and is 0000 at every other time.
- R6: Store data on `mem_wdata_o` is the low byte of `wr_data_i` repeated in all four lanes for a byte, the low halfword repeated twice for a halfword, and `wr_data_i` unchanged for a word.
- R7: In the second cycle of a load, `rd_data_o` holds the addressed byte or halfword of `mem_rdata_i` (chosen as in R4) in its low bits. The upper bits are zero-extended when `acc_sgn_i` = 0 and sign-extended when it is 1. A word load returns `mem_rdata_i` as is.
- R8: At the edge that ends the second cycle of an access, `opcode_o` becomes the word fetched during the first cycle. At the edge that ends the first cycle, `opcode_o` is unchanged.
- R9: While `pause_i` is high, the current opcode, the next opcode and the access phase all hold, and `stall_o` is 1.
- R10: Asynchronous reset loads the no-operation word (`NOP_OP`, default 0) into both opcode registers and returns the sequencer to the fetch phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pause_i | input | 1 | Memory not ready; freezes all state |
| endian_i | input | 2 | Byte order: 00 big-endian, 11 little-endian |
| pc_i | input | 32 | Instruction fetch address |
| dat_addr_i | input | 32 | Load/store byte address |
| wr_data_i | input | 32 | Store data, right-aligned |
| acc_size_i | input | 2 | 00 none, 01 byte, 10 halfword, 11 word |
| acc_wr_i | input | 1 | 1 = store, 0 = load |
| acc_sgn_i | input | 1 | Sign-extend a byte or halfword load |
| opcode_o | output | 32 | Current opcode |
| rd_data_o | output | 32 | Aligned and extended load result |
| stall_o | output | 1 | Datapath must hold its state this cycle |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write bus |
| mem_rdata_i | input | 32 | Memory read bus |
| mem_sel_o | output | 4 | Byte lanes written |
| mem_we_o | output | 1 | Memory write strobe |

## Verification
The address, stall, strobe, lane-select, write-data and load-result outputs depend combinationally on the inputs and the access phase. They are due in the same cycle the stimulus is applied, so the bench checks them 1 ns after it drives inputs on the falling edge. The opcode register is due one edge later, and the bench reads it 1 ns after the rising edge that should load it. A bench-side model of the phase, the current opcode and the parked opcode advances only on unpaused edges, so every expected value refers to the cycle in which it falls due.

// File: rtl/memacc_pkg.sv
package memacc_pkg;
  typedef enum logic [1:0] {
    SZ_NONE = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10,
    SZ_WORD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/memacc_lane_dec.sv
module memacc_lane_dec
  import memacc_pkg::*;
#(
  parameter int LANES = 4,
  localparam int LB = $clog2(LANES)
) (
  input  logic [LB-1:0]    off_i,
  input  logic [LB-1:0]    endian_i,
  input  acc_size_e        size_i,
  output logic [LB-1:0]    lane_o,
  output logic [LANES-1:0] lanes_o
);
  // endian 00 mirrors the offset, 11 keeps it
  assign lane_o = off_i ^ ~endian_i;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LB-1:0] IDX = LB'(i);
    always_comb begin
      unique case (size_i)
        SZ_BYTE: lanes_o[i] = (lane_o == IDX);
        SZ_HALF: lanes_o[i] = (lane_o[LB-1:1] == IDX[LB-1:1]);
        SZ_WORD: lanes_o[i] = 1'b1;
        default: lanes_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/memacc_load_align.sv
module memacc_load_align
  import memacc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LB = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [LB-1:0]     lane_i,
  input  acc_size_e         size_i,
  input  logic              sgn_i,
  output logic [DATA_W-1:0] data_o
);
  logic [7:0]  byte_s;
  logic [15:0] half_s;

  assign byte_s = word_i[8*lane_i +: 8];
  assign half_s = word_i[16*lane_i[LB-1:1] +: 16];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(DATA_W-8){sgn_i & byte_s[7]}}, byte_s};
      SZ_HALF: data_o = {{(DATA_W-16){sgn_i & half_s[15]}}, half_s};
      default: data_o = word_i;
    endcase
  end
endmodule

// File: rtl/memacc_store_rep.sv
module memacc_store_rep
  import memacc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  acc_size_e         size_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] rep_b, rep_h;

  for (genvar i = 0; i < LANES; i++) begin : g_rep_b
    assign rep_b[8*i +: 8] = data_i[7:0];
  end
  for (genvar i = 0; i < LANES / 2; i++) begin : g_rep_h
    assign rep_h[16*i +: 16] = data_i[15:0];
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = rep_b;
      SZ_HALF: data_o = rep_h;
      default: data_o = data_i;
    endcase
  end
endmodule

// File: rtl/memacc_ctrl.sv
module memacc_ctrl
  import memacc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter logic [DATA_W-1:0] NOP_OP = '0,
  localparam int LANES = DATA_W / 8,
  localparam int LB = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pause_i,
  input  logic [LB-1:0]     endian_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] dat_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        acc_size_i,
  input  logic              acc_wr_i,
  input  logic              acc_sgn_i,
  output logic [DATA_W-1:0] opcode_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              stall_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [LANES-1:0]  mem_sel_o,
  output logic              mem_we_o
);
  acc_size_e         size;
  logic              access;
  logic              setup_q;
  logic [DATA_W-1:0] opcode_q, next_op_q;
  logic [LB-1:0]     lane;
  logic [LANES-1:0]  lanes;

  assign size   = acc_size_e'(acc_size_i);
  assign access = (size != SZ_NONE);

  // setup_q: fetch half of a data access is done, data half pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_q   <= 1'b0;
      opcode_q  <= NOP_OP;
      next_op_q <= NOP_OP;
    end else if (!pause_i) begin
      if (setup_q) begin
        opcode_q <= next_op_q;
        setup_q  <= 1'b0;
      end else if (access) begin
        next_op_q <= mem_rdata_i;
        setup_q   <= 1'b1;
      end else begin
        opcode_q <= mem_rdata_i;
      end
    end
  end

  memacc_lane_dec #(.LANES(LANES)) i_lane_dec (
    .off_i    (dat_addr_i[LB-1:0]),
    .endian_i (endian_i),
    .size_i   (size),
    .lane_o   (lane),
    .lanes_o  (lanes)
  );

  memacc_load_align #(.DATA_W(DATA_W)) i_load_align (
    .word_i (mem_rdata_i),
    .lane_i (lane),
    .size_i (size),
    .sgn_i  (acc_sgn_i),
    .data_o (rd_data_o)
  );

  memacc_store_rep #(.DATA_W(DATA_W)) i_store_rep (
    .data_i (wr_data_i),
    .size_i (size),
    .data_o (mem_wdata_o)
  );

  assign mem_addr_o = setup_q ? dat_addr_i : pc_i;
  assign mem_we_o   = setup_q & access & acc_wr_i;
  assign mem_sel_o  = mem_we_o ? lanes : '0;
  assign stall_o    = (access & ~setup_q) | pause_i;
  assign opcode_o   = opcode_q;
endmodule

// File: rtl/memacc_chk.sv
module memacc_chk #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] NOP_OP = '0,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pause_i,
  input logic [1:0]        acc_size_i,
  input logic              stall_o,
  input logic              mem_we_o,
  input logic [LANES-1:0]  mem_sel_o,
  input logic [DATA_W-1:0] opcode_o,
  input logic              setup_q,
  input logic [DATA_W-1:0] next_op_q
);
  p_enter_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_size_i != 2'b00 && !setup_q && !pause_i) |=> setup_q);

  p_single_extra_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_q && !pause_i) |=> !setup_q);

  p_no_write_fetch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !setup_q |-> !mem_we_o);

  p_sel_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_o |-> (mem_sel_o == '0));

  p_word_lanes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && acc_size_i == 2'b11) |-> (mem_sel_o == '1));

  p_byte_lane_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && acc_size_i == 2'b01) |-> ($countones(mem_sel_o) == 1));

  p_half_lanes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && acc_size_i == 2'b10) |-> ($countones(mem_sel_o) == 2));

  p_handoff_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_q && !pause_i) |=> (opcode_o == $past(next_op_q)));

  p_pause_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |=> ($stable(opcode_o) && $stable(setup_q) && $stable(next_op_q)));

  p_pause_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |-> stall_o);

  p_reset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (opcode_o == NOP_OP && !setup_q));
endmodule

bind memacc_ctrl memacc_chk #(.DATA_W(DATA_W), .NOP_OP(NOP_OP)) i_memacc_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pause_i    (pause_i),
  .acc_size_i (acc_size_i),
  .stall_o    (stall_o),
  .mem_we_o   (mem_we_o),
  .mem_sel_o  (mem_sel_o),
  .opcode_o   (opcode_o),
  .setup_q    (setup_q),
  .next_op_q  (next_op_q)
);

// File: tb/test_memacc_ctrl.sv
module test_memacc_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pause_i = 1'b0;
  logic [1:0]  endian_i = 2'b00;
  logic [31:0] pc_i = '0, dat_addr_i = '0, wr_data_i = '0;
  logic [1:0]  acc_size_i = 2'b00;
  logic        acc_wr_i = 1'b0, acc_sgn_i = 1'b0;
  logic [31:0] opcode_o, rd_data_o, mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        stall_o, mem_we_o;
  logic [3:0]  mem_sel_o;

  logic [31:0] mem [0:255];
  assign mem_rdata_i = mem[mem_addr_o[9:2]];

  int n_chk = 0, n_fail = 0;
  logic        exp_setup;
  logic [31:0] exp_op, exp_next;

  always #5 clk_i = ~clk_i;

  memacc_ctrl i_memacc_ctrl (
    .clk_i, .rst_ni, .pause_i, .endian_i, .pc_i, .dat_addr_i, .wr_data_i,
    .acc_size_i, .acc_wr_i, .acc_sgn_i, .opcode_o, .rd_data_o, .stall_o,
    .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_sel_o, .mem_we_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] f_sel(input logic [1:0] sz, input logic [1:0] off, input logic big);
    logic hi;
    hi = big ? !off[1] : off[1];
    case (sz)
      2'b01:   return big ? (4'b1000 >> off) : (4'b0001 << off);
      2'b10:   return hi ? 4'b1100 : 4'b0011;
      2'b11:   return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] f_wdata(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'b01:   return {4{d[7:0]}};
      2'b10:   return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] f_rdata(input logic [1:0] sz, input logic sgn,
                                          input logic [1:0] off, input logic big,
                                          input logic [31:0] w);
    logic [7:0] b;
    logic [15:0] h;
    logic hi;
    b  = big ? w[8*(3-off) +: 8] : w[8*off +: 8];
    hi = big ? !off[1] : off[1];
    h  = hi ? w[31:16] : w[15:0];
    case (sz)
      2'b01:   return sgn ? {{24{b[7]}}, b} : {24'b0, b};
      2'b10:   return sgn ? {{16{h[15]}}, h} : {16'b0, h};
      default: return w;
    endcase
  endfunction

  // One clock: drive at falling edge, check combinational outputs, then the edge result
  task automatic step(input logic [31:0] pc, input logic [31:0] da, input logic [31:0] wd,
                      input logic [1:0] sz, input logic wr, input logic sgn,
                      input logic [1:0] en, input logic pz);
    logic big;
    logic [3:0] es;
    logic [31:0] ew;
    @(negedge clk_i);
    pc_i = pc; dat_addr_i = da; wr_data_i = wd; acc_size_i = sz;
    acc_wr_i = wr; acc_sgn_i = sgn; endian_i = en; pause_i = pz;
    big = (en == 2'b00);
    #1;
    if (!exp_setup) begin
      chk("R1 fetch address", mem_addr_o, pc);
      chk("R2 first-cycle stall", {31'b0, stall_o}, {31'b0, (sz != 2'b00) | pz});
      chk("R3 no write in fetch", {31'b0, mem_we_o}, 32'd0);
      chk("R5 sel idle", {28'b0, mem_sel_o}, 32'd0);
    end else begin
      es = (wr && sz != 2'b00) ? f_sel(sz, da[1:0], big) : 4'b0000;
      ew = f_wdata(sz, wd);
      chk("R2 data address", mem_addr_o, da);
      chk("R2 second-cycle stall", {31'b0, stall_o}, {31'b0, pz});
      chk("R3 write strobe", {31'b0, mem_we_o}, {31'b0, wr && sz != 2'b00});
      chk("R4 R5 lane select", {28'b0, mem_sel_o}, {28'b0, es});
      if (wr) chk("R6 store data", mem_wdata_o, ew);
      else    chk("R7 load data", rd_data_o, f_rdata(sz, sgn, da[1:0], big, mem[da[9:2]]));
      if (wr && !pz)
        for (int k = 0; k < 4; k++)
          if (es[k]) mem[da[9:2]][8*k +: 8] = ew[8*k +: 8];
    end
    @(posedge clk_i);
    if (!pz) begin
      if (exp_setup) begin
        exp_op = exp_next;
        exp_setup = 1'b0;
      end else if (sz != 2'b00) begin
        exp_next = mem[pc[9:2]];
        exp_setup = 1'b1;
      end else begin
        exp_op = mem[pc[9:2]];
      end
    end
    #1;
    chk(pz ? "R9 opcode held in pause" : "R1 R8 opcode update", opcode_o, exp_op);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    logic [1:0] sz, en;
    logic wr, sg, pz;
    logic [31:0] pc, da, wd;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = (32'(i) * 32'h9E37_79B1) ^ 32'h5A0F_C3E1;
    mem[8] = 32'h80FF_7F01;
    exp_setup = 1'b0; exp_op = 32'h0; exp_next = 32'h0;
    #12;
    chk("R10 reset opcode", opcode_o, 32'h0);
    chk("R10 reset fetch phase", {31'b0, mem_we_o | stall_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R1 plain fetches
    step(32'h10, 0, 0, 2'b00, 0, 0, 2'b00, 0);
    step(32'h14, 0, 0, 2'b00, 0, 0, 2'b00, 0);
    // R7 signed byte loads, big then little, at every offset of 0x80FF7F01
    for (int k = 0; k < 4; k++) begin
      step(32'h18, 32'h20 + k, 0, 2'b01, 0, 1, 2'b00, 0);
      step(32'h18, 32'h20 + k, 0, 2'b01, 0, 1, 2'b00, 0);
      step(32'h1C, 32'h20 + k, 0, 2'b01, 0, 1, 2'b11, 0);
      step(32'h1C, 32'h20 + k, 0, 2'b01, 0, 1, 2'b11, 0);
    end
    // R7 halfword zero-extend, odd offset ignores bit 0 (R4)
    step(32'h24, 32'h23, 0, 2'b10, 0, 0, 2'b00, 0);
    step(32'h24, 32'h23, 0, 2'b10, 0, 0, 2'b00, 0);
    // R9 pause in fetch phase, first access cycle and second access cycle
    step(32'h28, 0, 0, 2'b00, 0, 0, 2'b00, 1);
    step(32'h28, 32'h41, 32'hCAFE_BEEF, 2'b01, 1, 0, 2'b11, 1);
    step(32'h28, 32'h41, 32'hCAFE_BEEF, 2'b01, 1, 0, 2'b11, 0);
    step(32'h28, 32'h41, 32'hCAFE_BEEF, 2'b01, 1, 0, 2'b11, 1);
    step(32'h28, 32'h41, 32'hCAFE_BEEF, 2'b01, 1, 0, 2'b11, 0);
    // R6 halfword and word stores
    step(32'h2C, 32'h46, 32'h1234_5678, 2'b10, 1, 0, 2'b00, 0);
    step(32'h2C, 32'h46, 32'h1234_5678, 2'b10, 1, 0, 2'b00, 0);
    step(32'h30, 32'h48, 32'h0BAD_F00D, 2'b11, 1, 0, 2'b00, 0);
    step(32'h30, 32'h48, 32'h0BAD_F00D, 2'b11, 1, 0, 2'b00, 0);

    // constrained random mix
    sz = 0; en = 0; wr = 0; sg = 0; pc = 0; da = 0; wd = 0;
    for (int n = 0; n < 600; n++) begin
      if (!exp_setup) begin
        pc = {22'b0, 8'($urandom), 2'b00};
        sz = ($urandom % 3 == 0) ? 2'b00 : 2'($urandom);
        wr = (sz != 2'b00) && $urandom % 2 == 1;
        sg = 1'($urandom);
        en = ($urandom % 2 == 1) ? 2'b11 : 2'b00;
        da = {22'b0, 10'($urandom)};
        wd = $urandom;
      end
      pz = ($urandom % 8 == 0);
      step(pc, da, wd, sz, wr, sg, en, pz);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule